// File: doc/BRIEF.md
# Sigma-Delta Conversion Cadence Generator

This block produces the timing of conversion results for a multichannel sigma-delta converter without doing any of the signal arithmetic. It counts master clock cycles and drives an active-low result strobe at the cycle in which a result would exist. The count depends on a 10-bit filter word and on three shape controls: filter order (fourth or third), chopping and zero-latency operation. There are two timing rules. The first result after a channel switch, start or restart waits a full settling interval. Results that follow on the same channel come once per conversion period.

The block has two operating styles. In continuous operation it starts settling on its own whenever it is idle with a legal filter word, and then repeats for as long as it runs. In one-shot operation it sleeps until a start request, settles, delivers exactly one result and sleeps again. A channel switch during a conversion abandons the count and settles again. A filter word of zero is illegal. It halts all counting and raises an error flag.

Top module: `sd_conv_timer`

## Requirements
- R1: While reset is held, data_rdy_n is 1, busy is 0, power_down is 1 and cfg_err is 0.
- R2: A conversion begun at clock edge E completes at edge E+S, where data_rdy_n goes to 0. S is the settling count: chop_on=0 gives 4096·FS+507 for fourth order (third_order=0) and 3072·FS+507 for third order (third_order=1); chop_on=1 gives 8192·FS+523 for fourth order and 6144·FS+523 for third order.
- R3: When zero_lat=0, successive results in continuous operation are P edges apart. P is 1024·FS for either order with chop_on=0, and 4096·FS+16 (fourth order) or 3072·FS+16 (third order) with chop_on=1.
- R4: When zero_lat=1, the continuous period P becomes 4096·FS or 3072·FS with chop_on=0, and 8192·FS+32 or 6144·FS+32 with chop_on=1 (fourth or third order).
- R5: A chan_switch pulse sampled while busy and the filter word is legal discards the running count and begins a new settling interval at that edge (R2 timing); data_rdy_n is 1 after that edge.
- R6: With one_shot=1, a start_req sampled while idle begins a settling interval. Busy is 1 for the whole interval. After the single result, busy returns to 0 and power_down to 1. power_down is always the inverse of busy.
- R7: With one_shot=1 and the block idle, a chan_switch pulse does not start a conversion; busy stays 0.
- R8: A filter word of 0 sampled at an edge makes cfg_err 1 and busy 0 after that edge, with no result produced. Once the word is legal again, continuous operation restarts with a full settling interval.
- R9: data_rdy_n returns to 1 after an edge that samples read_ack, after an edge that begins a new conversion, or one edge before the next continuous result (P−1 edges after the previous result). A result completing at the same edge takes priority and drives it to 0.
- R10: With one_shot=0, the first edge after reset release (legal FS) begins a settling interval, so the first result appears S edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_word | input | 10 | Filter word FS; 0 is illegal |
| third_order | input | 1 | 1 selects the third-order filter, 0 selects fourth order |
| chop_on | input | 1 | Chopping enable |
| zero_lat | input | 1 | Zero-latency continuous period |
| one_shot | input | 1 | 1 selects one-shot operation, 0 selects continuous |
| start_req | input | 1 | Start pulse for one-shot operation |
| chan_switch | input | 1 | Channel switch pulse |
| read_ack | input | 1 | Result consumed; releases data_rdy_n |
| data_rdy_n | output | 1 | Active-low result-available flag |
| busy | output | 1 | A conversion is being timed |
| power_down | output | 1 | The block is idle |
| cfg_err | output | 1 | Filter word is illegal |

## Verification
A down-counter loaded with the wrong duration, or decremented wrongly, shows at the ports as a result edge that is early or late by a measurable number of clocks. The error is visible within one settling interval or period of a few thousand cycles. A wrong state register shows up sooner. busy and power_down disagree with the expected mode on the very next clock, and a missed restart leaves data_rdy_n low after a channel switch edge. Every cycle is compared against a behavioural model, so any divergence is reported at the first clock where it reaches a port.

// File: rtl/sd_tmg_pkg.sv
package sd_tmg_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_e;

    // Fixed cycle offsets added to the scaled filter word
    localparam int unsigned SETTLE_OFS_PLAIN = 507;
    localparam int unsigned SETTLE_OFS_CHOP  = 523;
    localparam int unsigned PERIOD_OFS_CHOP  = 16;
    localparam int unsigned PERIOD_OFS_ZLAT  = 32;

endpackage

// File: rtl/sd_dur_calc.sv
module sd_dur_calc #(
    parameter int FS_W  = 10,
    parameter int CNT_W = FS_W + 14
) (
    input  logic [FS_W-1:0]  fs,
    input  logic             third,
    input  logic             chop,
    input  logic             zlat,
    output logic [CNT_W-1:0] settle,
    output logic [CNT_W-1:0] period
);
    import sd_tmg_pkg::*;

    logic [CNT_W-1:0] fs_x;
    logic [CNT_W-1:0] m1k, m3k, m4k, m6k, m8k;

    // Multiples of FS built from shifts and adds
    always_comb begin
        fs_x = {{(CNT_W-FS_W){1'b0}}, fs};
        m1k  = fs_x << 10;
        m4k  = fs_x << 12;
        m8k  = fs_x << 13;
        m3k  = (fs_x << 11) + (fs_x << 10);
        m6k  = (fs_x << 12) + (fs_x << 11);
    end

    always_comb begin
        if (chop) begin
            settle = (third ? m6k : m8k) + CNT_W'(SETTLE_OFS_CHOP);
        end else begin
            settle = (third ? m3k : m4k) + CNT_W'(SETTLE_OFS_PLAIN);
        end
    end

    always_comb begin
        case ({zlat, chop})
            2'b00:   period = m1k;
            2'b01:   period = (third ? m3k : m4k) + CNT_W'(PERIOD_OFS_CHOP);
            2'b10:   period = third ? m3k : m4k;
            default: period = (third ? m6k : m8k) + CNT_W'(PERIOD_OFS_ZLAT);
        endcase
    end

endmodule

// File: rtl/sd_conv_fsm.sv
module sd_conv_fsm #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fs_zero,
    input  logic             one_shot,
    input  logic             start_req,
    input  logic             chan_switch,
    input  logic [CNT_W-1:0] settle,
    input  logic [CNT_W-1:0] period,
    output logic             busy,
    output logic             cfg_err,
    output logic             done,
    output logic             restart,
    output logic             near
);
    import sd_tmg_pkg::*;

    typedef struct packed {
        run_e             state;
        logic [CNT_W-1:0] cnt;
        logic             err;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.err = fs_zero;
        done     = 1'b0;
        restart  = 1'b0;
        near     = 1'b0;
        case (st_q.state)
            ST_IDLE: begin
                if (!fs_zero && (!one_shot || start_req)) begin
                    st_d.state = ST_RUN;
                    st_d.cnt   = settle;
                    restart    = 1'b1;
                end
            end
            default: begin
                if (fs_zero) begin
                    st_d.state = ST_IDLE;
                    st_d.cnt   = '0;
                end else if (chan_switch) begin
                    st_d.cnt = settle;
                    restart  = 1'b1;
                end else if (st_q.cnt == CNT_W'(1)) begin
                    done = 1'b1;
                    if (one_shot) begin
                        st_d.state = ST_IDLE;
                        st_d.cnt   = '0;
                    end else begin
                        st_d.cnt = period;
                    end
                end else begin
                    near     = (st_q.cnt == CNT_W'(2));
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.cnt   <= '0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy    = (st_q.state == ST_RUN);
    assign cfg_err = st_q.err;

    assert_cnt_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.cnt != '0));

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && chan_switch && !fs_zero) |=> (busy && st_q.cnt == $past(settle)));

    assert_one_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && one_shot) |=> !busy);

    assert_ignore_switch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && one_shot && !start_req && chan_switch) |=> !busy);

    assert_bad_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fs_zero |=> (!busy && cfg_err));

endmodule

// File: rtl/sd_rdy_ctrl.sv
module sd_rdy_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic restart,
    input  logic near,
    input  logic read_ack,
    output logic rdy_n
);

    typedef struct packed {
        logic rdy_n;
    } rdy_t;

    rdy_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (read_ack || restart || near) begin
            r_d.rdy_n = 1'b1;
        end
        if (done) begin
            r_d.rdy_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.rdy_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdy_n = r_q.rdy_n;

    assert_result_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !rdy_n);

    assert_ack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (read_ack && !done) |=> rdy_n);

    assert_restart_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> rdy_n);

endmodule

// File: rtl/sd_conv_timer.sv
module sd_conv_timer #(
    parameter int FS_W = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [FS_W-1:0] fs_word,
    input  logic            third_order,
    input  logic            chop_on,
    input  logic            zero_lat,
    input  logic            one_shot,
    input  logic            start_req,
    input  logic            chan_switch,
    input  logic            read_ack,
    output logic            data_rdy_n,
    output logic            busy,
    output logic            power_down,
    output logic            cfg_err
);
    localparam int CNT_W = FS_W + 14;

    logic [CNT_W-1:0] settle_w, period_w;
    logic             done_w, restart_w, near_w, busy_w;

    sd_dur_calc #(
        .FS_W  (FS_W),
        .CNT_W (CNT_W)
    ) u_dur (
        .fs     (fs_word),
        .third  (third_order),
        .chop   (chop_on),
        .zlat   (zero_lat),
        .settle (settle_w),
        .period (period_w)
    );

    sd_conv_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_zero     (fs_word == '0),
        .one_shot    (one_shot),
        .start_req   (start_req),
        .chan_switch (chan_switch),
        .settle      (settle_w),
        .period      (period_w),
        .busy        (busy_w),
        .cfg_err     (cfg_err),
        .done        (done_w),
        .restart     (restart_w),
        .near        (near_w)
    );

    sd_rdy_ctrl u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (done_w),
        .restart  (restart_w),
        .near     (near_w),
        .read_ack (read_ack),
        .rdy_n    (data_rdy_n)
    );

    assign busy       = busy_w;
    assign power_down = !busy_w;

    assert_pd_inverse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        power_down != busy);

endmodule

// File: tb/test_sd_conv_timer.sv
module test_sd_conv_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [9:0] fs_word;
    logic       third_order, chop_on, zero_lat, one_shot;
    logic       start_req, chan_switch, read_ack;
    logic       data_rdy_n, busy, power_down, cfg_err;

    int  n_chk = 0;
    int  n_err = 0;
    bit  finished = 0;
    bit  cmp_on = 0;

    always #4 clk = ~clk;

    sd_conv_timer i_sd_conv_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fs_word     (fs_word),
        .third_order (third_order),
        .chop_on     (chop_on),
        .zero_lat    (zero_lat),
        .one_shot    (one_shot),
        .start_req   (start_req),
        .chan_switch (chan_switch),
        .read_ack    (read_ack),
        .data_rdy_n  (data_rdy_n),
        .busy        (busy),
        .power_down  (power_down),
        .cfg_err     (cfg_err)
    );

    // Durations from the requirement formulas
    function automatic int settle_of(int fs, bit third, bit chop);
        if (chop) return (third ? 6144 : 8192) * fs + 523;
        return (third ? 3072 : 4096) * fs + 507;
    endfunction

    function automatic int period_of(int fs, bit third, bit chop, bit zl);
        if (!zl && !chop) return 1024 * fs;
        if (!zl)          return (third ? 3072 : 4096) * fs + 16;
        if (!chop)        return (third ? 3072 : 4096) * fs;
        return (third ? 6144 : 8192) * fs + 32;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // Behavioural reference model
    bit m_run;
    int m_cnt;
    bit m_rdy;
    bit m_err;

    always @(posedge clk) begin : model
        bit fz, dn, rs, nr;
        int s, p;
        cmp_on <= 1;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_rdy = 1; m_err = 0;
        end else begin
            fz = (fs_word == 0);
            s  = settle_of(int'(fs_word), third_order, chop_on);
            p  = period_of(int'(fs_word), third_order, chop_on, zero_lat);
            dn = 0; rs = 0; nr = 0;
            if (!m_run) begin
                if (!fz && (!one_shot || start_req)) begin
                    m_run = 1; m_cnt = s; rs = 1;
                end
            end else if (fz) begin
                m_run = 0; m_cnt = 0;
            end else if (chan_switch) begin
                m_cnt = s; rs = 1;
            end else if (m_cnt == 1) begin
                dn = 1;
                if (one_shot) begin m_run = 0; m_cnt = 0; end
                else m_cnt = p;
            end else begin
                nr = (m_cnt == 2);
                m_cnt = m_cnt - 1;
            end
            if (read_ack || rs || nr) m_rdy = 1;
            if (dn) m_rdy = 0;
            m_err = fz;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk(data_rdy_n == m_rdy, "R9 data_rdy_n vs model", data_rdy_n, m_rdy);
            chk(busy == m_run, "R6 busy vs model", busy, m_run);
            chk(power_down == !m_run, "R6 power_down vs model", power_down, !m_run);
            chk(cfg_err == m_err, "R8 cfg_err vs model", cfg_err, m_err);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "timeout watchdog", 0, 1);
        finish_run();
    end

    // Count edges until data_rdy_n is low (0 if already low)
    task automatic wait_fall(output int k);
        k = 0;
        while (data_rdy_n === 1'b1 && k < 20000) begin
            @(negedge clk);
            k++;
        end
    endtask

    // Count edges from a result to the next result
    task automatic next_period(output int k);
        bit hi;
        k = 0; hi = 0;
        do begin
            @(negedge clk);
            k++;
            if (data_rdy_n) hi = 1;
        end while (!(hi && !data_rdy_n) && k < 20000);
    endtask

    task automatic pulse_switch();
        @(negedge clk) chan_switch = 1;
        @(negedge clk) chan_switch = 0;
    endtask

    initial begin
        int k;
        rst_n = 0; fs_word = 10'd1; third_order = 0; chop_on = 0; zero_lat = 0;
        one_shot = 1; start_req = 0; chan_switch = 0; read_ack = 0;
        repeat (3) @(negedge clk);
        chk(data_rdy_n == 1, "R1 reset data_rdy_n", data_rdy_n, 1);
        chk(busy == 0, "R1 reset busy", busy, 0);
        chk(power_down == 1, "R1 reset power_down", power_down, 1);
        chk(cfg_err == 0, "R1 reset cfg_err", cfg_err, 0);
        rst_n = 1;
        repeat (5) @(negedge clk);
        chk(power_down == 1, "R6 one-shot idle after reset", power_down, 1);

        // R7: switch in one-shot idle starts nothing
        pulse_switch();
        repeat (10) @(negedge clk);
        chk(busy == 0, "R7 switch while idle", busy, 0);

        // R6: one-shot conversion
        @(negedge clk) start_req = 1;
        @(negedge clk) start_req = 0;
        chk(busy == 1, "R6 busy after start", busy, 1);
        wait_fall(k);
        chk(k == settle_of(1, 0, 0), "R6 one-shot settle", k, settle_of(1, 0, 0));
        chk(power_down == 1, "R6 back to power_down", power_down, 1);
        repeat (20) @(negedge clk);
        chk(data_rdy_n == 0 && busy == 0, "R6 single result only", data_rdy_n, 0);
        @(negedge clk) read_ack = 1;
        @(negedge clk) read_ack = 0;
        chk(data_rdy_n == 1, "R9 release by read_ack", data_rdy_n, 1);

        // R10: continuous start, then R3 period
        @(negedge clk) one_shot = 0;
        @(negedge clk);
        wait_fall(k);
        chk(k == settle_of(1, 0, 0), "R10 continuous first result", k, settle_of(1, 0, 0));
        next_period(k);
        chk(k == period_of(1, 0, 0, 0), "R3 period fourth plain", k, period_of(1, 0, 0, 0));
        next_period(k);
        chk(k == period_of(1, 0, 0, 0), "R3 period repeat", k, period_of(1, 0, 0, 0));

        // R2 + R4: third order, chop, zero latency
        @(negedge clk) begin third_order = 1; chop_on = 1; zero_lat = 1; end
        pulse_switch();
        wait_fall(k);
        chk(k == settle_of(1, 1, 1), "R2 settle third chop", k, settle_of(1, 1, 1));
        next_period(k);
        chk(k == period_of(1, 1, 1, 1), "R4 period third chop", k, period_of(1, 1, 1, 1));

        // R2 + R3: fourth order, chop
        @(negedge clk) begin third_order = 0; zero_lat = 0; end
        pulse_switch();
        wait_fall(k);
        chk(k == settle_of(1, 0, 1), "R2 settle fourth chop", k, settle_of(1, 0, 1));
        next_period(k);
        chk(k == period_of(1, 0, 1, 0), "R3 period fourth chop", k, period_of(1, 0, 1, 0));

        // R2 + R4: third order, no chop, zero latency
        @(negedge clk) begin third_order = 1; chop_on = 0; zero_lat = 1; end
        pulse_switch();
        wait_fall(k);
        chk(k == settle_of(1, 1, 0), "R2 settle third plain", k, settle_of(1, 1, 0));
        next_period(k);
        chk(k == period_of(1, 1, 0, 1), "R4 period third plain", k, period_of(1, 1, 0, 1));

        // R5: switch in the middle of a conversion
        repeat (300) @(negedge clk);
        pulse_switch();
        chk(data_rdy_n == 1, "R5 ready released on switch", data_rdy_n, 1);
        wait_fall(k);
        chk(k == settle_of(1, 1, 0), "R5 restart settle", k, settle_of(1, 1, 0));

        // R8: illegal filter word
        @(negedge clk) fs_word = 10'd0;
        @(negedge clk);
        chk(cfg_err == 1 && busy == 0, "R8 error and halt", cfg_err, 1);
        repeat (30) @(negedge clk);
        chk(busy == 0 && data_rdy_n == 0, "R8 no activity", busy, 0);
        @(negedge clk) begin fs_word = 10'd2; third_order = 0; zero_lat = 0; end
        @(negedge clk);
        chk(cfg_err == 0, "R8 error cleared", cfg_err, 0);
        wait_fall(k);
        chk(k == settle_of(2, 0, 0), "R8 restart after legal word", k, settle_of(2, 0, 0));

        // R9: release one edge before the next result
        k = 0;
        while (!data_rdy_n && k < 20000) begin
            @(negedge clk);
            k++;
        end
        chk(k == period_of(2, 0, 0, 0) - 1, "R9 release before next result", k,
            period_of(2, 0, 0, 0) - 1);

        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule